// File: doc/BRIEF.md
# Serial CRC-5 Generator and Checker

This block computes a five-bit cyclic redundancy code over a bit-serial message for the short command frames of a UHF RFID link. The divisor is x^5 + x^3 + 1, the register starts from the non-zero value 01001, and one message bit is taken per clock whenever the valid strobe is high, most significant bit first. The remainder is always available in parallel. A separate shift-out request streams it out one bit per clock, MSB first, so a transmitter can append it to the frame.

The same datapath works as a checker. A receiver runs it over the message and then over the appended code. A good frame leaves the register at zero, and the residue flag reports this.

A small controller has three states. `ST_RUN` accepts message bits. `ST_DRAIN` streams the code out. `ST_SPENT` is reached after the fifth streamed bit and freezes the cleared register. Its transitions are: RUN to DRAIN on the first shift-out cycle, DRAIN to SPENT on the fifth shift-out cycle, and any state back to RUN on init or reset.

Top module: `crc5_serial_engine`

## Requirements
- R1: After a synchronous reset the register holds 01001, `crc_bit_o` is 0 and `residue_ok_o` is 0.
- R2: `init_i` reloads 01001 on the next edge from any state, and it wins over `bit_valid_i` and `shout_req_i` in the same cycle.
- R3: In ST_RUN, a cycle with `bit_valid_i` high (and no init or shift-out) applies one step. The feedback is register bit 4 XOR `bit_i`. The register shifts left with a 0 into bit 0, and it is XORed with 01001 when the feedback is 1. The result is visible on `crc_o` after that edge.
- R4: In ST_RUN, a cycle with `bit_valid_i` low, `init_i` low and `shout_req_i` low leaves `crc_o` unchanged.
- R5: After init, the 17-bit message 10000001000000000 fed MSB first yields `crc_o` = 10011.
- R6: `residue_ok_o` is 1 exactly when `crc_o` is 00000. Feeding a message followed by its own code gives 1 on the cycle after the last bit.
- R7: While `shout_req_i` is high in ST_RUN or ST_DRAIN, `crc_bit_o` shows register bit 4. The register then shifts left with zero fill and no feedback, so the code leaves MSB first.
- R8: After exactly 5 shift-out cycles the register is 00000 (ST_SPENT). It does not change under `bit_valid_i` or `shout_req_i` until init.
- R9: In ST_DRAIN, cycles with `shout_req_i` low hold the register, and `bit_valid_i` is ignored.
- R10: `crc_bit_o` is 0 in every cycle that is not a shift-out cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Reload preset and return to ST_RUN |
| bit_valid_i | input | 1 | `bit_i` is a message bit this cycle |
| bit_i | input | 1 | Serial message bit, MSB first |
| shout_req_i | input | 1 | Stream the code out this cycle |
| crc_bit_o | output | 1 | Serial code bit during shift-out |
| crc_o | output | 5 | Parallel remainder register |
| residue_ok_o | output | 1 | Register equals zero |

## Verification
The bench uses the known 17-bit vector with its code 10011, then random messages of random length with gaps in the valid strobe. A wrong feedback tap or a missing preset would produce a different code. The bench also drives init together with valid or shift-out; a design with the wrong priority would step the register instead of reloading it. Shift-out is checked with pauses, with valid pulses inside the drain, and with extra requests after the fifth bit. A design that applied feedback while draining, miscounted the drain, or let the spent register move would give a wrong serial bit or a non-zero register. Check-mode runs over message plus code confirm that the residue flag rises only on a true zero.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_SPENT = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_SHIFT = 2'd3
    } reg_op_e;
endpackage

// File: rtl/crc5_step.sv
// One division step: feedback = msb ^ din, shift left, conditional tap XOR.
module crc5_step #(
    parameter int          W    = 5,
    parameter logic [W-1:0] POLY = 5'b01001
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = cur[W-1] ^ din;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = fb & POLY[i];
        end else begin : g_up
            assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
        end
    end
endmodule

// File: rtl/crc5_ctrl.sv
// Mode controller: accumulate, drain, spent.
module crc5_ctrl
    import crc5_pkg::*;
#(
    parameter int W = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    init_i,
    input  logic    bit_valid_i,
    input  logic    shout_req_i,
    output reg_op_e op_o,
    output logic    shift_active_o,
    output state_e  state_o
);
    localparam int CNT_W = $clog2(W + 1);

    state_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (init_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (shout_req_i) begin
                        cnt_d   = CNT_W'(1);
                        state_d = (W == 1) ? ST_SPENT : ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (shout_req_i) begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(W - 1)) begin
                            state_d = ST_SPENT;
                        end
                    end
                end
                ST_SPENT: begin
                    state_d = ST_SPENT;
                end
                default: begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        op_o           = OP_HOLD;
        shift_active_o = 1'b0;
        if (init_i) begin
            op_o = OP_LOAD;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (shout_req_i) begin
                        op_o           = OP_SHIFT;
                        shift_active_o = 1'b1;
                    end else if (bit_valid_i) begin
                        op_o = OP_STEP;
                    end
                end
                ST_DRAIN: begin
                    if (shout_req_i) begin
                        op_o           = OP_SHIFT;
                        shift_active_o = 1'b1;
                    end
                end
                ST_SPENT: op_o = OP_HOLD;
                default:  op_o = OP_HOLD;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/crc5_rem_reg.sv
// Remainder register with load / step / shift / hold.
module crc5_rem_reg
    import crc5_pkg::*;
#(
    parameter int           W      = 5,
    parameter logic [W-1:0] PRESET = 5'b01001
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_op_e      op_i,
    input  logic [W-1:0] step_nxt_i,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= PRESET;
        end else begin
            unique case (op_i)
                OP_LOAD:  rem_q <= PRESET;
                OP_STEP:  rem_q <= step_nxt_i;
                OP_SHIFT: rem_q <= {rem_q[W-2:0], 1'b0};
                OP_HOLD:  rem_q <= rem_q;
                default:  rem_q <= rem_q;
            endcase
        end
    end

    assign rem_o = rem_q;
endmodule

// File: rtl/crc5_serial_engine.sv
module crc5_serial_engine
    import crc5_pkg::*;
#(
    parameter int           W      = 5,
    parameter logic [W-1:0] POLY   = 5'b01001,
    parameter logic [W-1:0] PRESET = 5'b01001
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         bit_valid_i,
    input  logic         bit_i,
    input  logic         shout_req_i,
    output logic         crc_bit_o,
    output logic [W-1:0] crc_o,
    output logic         residue_ok_o
);
    reg_op_e      op;
    logic         shift_active;
    state_e       state_q;
    logic [W-1:0] rem;
    logic [W-1:0] step_nxt;

    crc5_ctrl #(.W(W)) ctrl_i (
        .clk            (clk),
        .rst            (rst),
        .init_i         (init_i),
        .bit_valid_i    (bit_valid_i),
        .shout_req_i    (shout_req_i),
        .op_o           (op),
        .shift_active_o (shift_active),
        .state_o        (state_q)
    );

    crc5_step #(.W(W), .POLY(POLY)) step_i (
        .cur (rem),
        .din (bit_i),
        .nxt (step_nxt)
    );

    crc5_rem_reg #(.W(W), .PRESET(PRESET)) rem_i (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op),
        .step_nxt_i (step_nxt),
        .rem_o      (rem)
    );

    assign crc_o        = rem;
    assign crc_bit_o    = shift_active & rem[W-1];
    assign residue_ok_o = (rem == '0);
endmodule

// File: rtl/crc5_serial_engine_chk.sv
module crc5_serial_engine_chk
    import crc5_pkg::*;
#(
    parameter int           W      = 5,
    parameter logic [W-1:0] PRESET = 5'b01001
) (
    input logic         clk,
    input logic         rst,
    input logic         init_i,
    input logic         bit_valid_i,
    input logic         shout_req_i,
    input logic         crc_bit_o,
    input logic [W-1:0] crc_o,
    input logic         residue_ok_o,
    input state_e       state_q
);
    assert_reset_preset_R1: assert property (@(posedge clk)
        rst |=> (crc_o == PRESET));

    assert_init_preset_R2: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (crc_o == PRESET));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !init_i && !bit_valid_i && !shout_req_i) |=> $stable(crc_o));

    assert_shift_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (!init_i && shout_req_i && state_q != ST_SPENT) |=> (crc_o == {$past(crc_o[W-2:0]), 1'b0}));

    assert_spent_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPENT && !init_i) |=> (crc_o == '0 && residue_ok_o));

    assert_drain_pause_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && !init_i && !shout_req_i) |=> $stable(crc_o));

    assert_serial_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !shout_req_i) |-> !crc_bit_o);
endmodule

bind crc5_serial_engine crc5_serial_engine_chk #(.W(W), .PRESET(PRESET)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .init_i       (init_i),
    .bit_valid_i  (bit_valid_i),
    .shout_req_i  (shout_req_i),
    .crc_bit_o    (crc_bit_o),
    .crc_o        (crc_o),
    .residue_ok_o (residue_ok_o),
    .state_q      (state_q)
);

// File: tb/crc5_serial_engine_tb_top.sv
`timescale 1ns/1ps
module crc5_serial_engine_tb_top;
    localparam logic [4:0] PRE = 5'b01001;
    localparam logic [4:0] TAP = 5'b01001;

    logic       clk = 1'b0;
    logic       rst, init_i, bit_valid_i, bit_i, shout_req_i;
    logic       crc_bit_o, residue_ok_o;
    logic [4:0] crc_o;

    int vectors = 0;
    int miscompares = 0;

    // bench model of the requirements
    logic [4:0] m_reg;
    int         m_st;   // 0 run, 1 drain, 2 spent
    int         m_cnt;

    always #4 clk = ~clk;

    crc5_serial_engine dut_i (
        .clk(clk), .rst(rst), .init_i(init_i), .bit_valid_i(bit_valid_i),
        .bit_i(bit_i), .shout_req_i(shout_req_i), .crc_bit_o(crc_bit_o),
        .crc_o(crc_o), .residue_ok_o(residue_ok_o)
    );

    function automatic logic [4:0] ref_step(logic [4:0] r, logic b);
        logic fb;
        logic [4:0] n;
        fb = r[4] ^ b;
        n  = {r[3:0], 1'b0};
        if (fb) n = n ^ TAP;
        return n;
    endfunction

    function automatic logic [4:0] ref_crc(logic [31:0] msg, int len);
        logic [4:0] r;
        r = PRE;
        for (int i = len - 1; i >= 0; i--) r = ref_step(r, msg[i]);
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, check pre-edge outputs, update model, check post-edge
    task automatic tick(string tag, logic i, logic v, logic b, logic s);
        logic exp_ser;
        init_i = i; bit_valid_i = v; bit_i = b; shout_req_i = s;
        #1;
        exp_ser = (!i && s && m_st != 2) ? m_reg[4] : 1'b0;
        check({tag, " serial bit (R7/R10)"}, 32'(crc_bit_o), 32'(exp_ser));
        @(posedge clk);
        if (i) begin
            m_reg = PRE; m_st = 0; m_cnt = 0;
        end else if (s && m_st != 2) begin
            m_reg = {m_reg[3:0], 1'b0};
            m_cnt++;
            m_st = (m_cnt == 5) ? 2 : 1;
        end else if (m_st == 0 && v) begin
            m_reg = ref_step(m_reg, b);
        end
        @(negedge clk);
        check({tag, " crc_o (R3/R4/R8/R9)"}, 32'(crc_o), 32'(m_reg));
        check({tag, " residue flag (R6)"}, 32'(residue_ok_o), 32'(m_reg == 5'b0));
    endtask

    task automatic feed(string tag, logic [31:0] msg, int len);
        for (int k = len - 1; k >= 0; k--) tick(tag, 1'b0, 1'b1, msg[k], 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [31:0] golden;
        logic [4:0]  serial;
        void'($urandom(32'd7331));
        rst = 1'b1; init_i = 0; bit_valid_i = 0; bit_i = 0; shout_req_i = 0;
        m_reg = PRE; m_st = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset crc", 32'(crc_o), 32'(PRE));
        check("R1 reset residue", 32'(residue_ok_o), 0);
        check("R1 reset serial", 32'(crc_bit_o), 0);

        // R5 golden vector
        golden = 32'b1_0000_0010_0000_0000;
        tick("R2 init", 1, 0, 0, 0);
        feed("R5 golden", golden, 17);
        check("R5 golden crc", 32'(crc_o), 32'b10011);
        check("R5 model crc", 32'(ref_crc(golden, 17)), 32'b10011);

        // R7 shift out golden code, with a pause (R9) and a valid pulse in drain
        serial = '0;
        for (int k = 0; k < 5; k++) begin
            if (k == 2) begin
                tick("R9 pause", 0, 0, 0, 0);
                tick("R9 valid in drain", 0, 1, 1, 0);
            end
            shout_req_i = 1; init_i = 0; bit_valid_i = 0;
            #1 serial = {serial[3:0], crc_bit_o};
            tick("R7 shift", 0, 0, 0, 1);
        end
        check("R7 serial code", 32'(serial), 32'b10011);
        check("R8 cleared", 32'(crc_o), 0);
        // R8 frozen after drain
        tick("R8 shout after spent", 0, 0, 0, 1);
        tick("R8 valid after spent", 0, 1, 1, 0);
        check("R8 still zero", 32'(crc_o), 0);

        // R6 check mode: message plus code
        tick("R2 init", 1, 0, 0, 0);
        feed("R6 check", {golden[26:0], 5'b10011}, 22);
        check("R6 residue ok", 32'(residue_ok_o), 1);
        tick("R2 init", 1, 0, 0, 0);
        feed("R6 bad frame", {golden[26:0], 5'b10010}, 22);
        check("R6 residue bad", 32'(residue_ok_o), 0);

        // R2 init collisions
        tick("R3 step", 0, 1, 1, 0);
        tick("R2 init beats valid", 1, 1, 1, 0);
        check("R2 preset after collision", 32'(crc_o), 32'(PRE));
        tick("R7 start drain", 0, 0, 0, 1);
        tick("R2 init beats shout", 1, 0, 0, 1);
        check("R2 preset after shout collision", 32'(crc_o), 32'(PRE));

        // random frames: message, gaps, then append or check
        for (int f = 0; f < 200; f++) begin
            int          len;
            logic [31:0] msg;
            logic [4:0]  code;
            len = 1 + int'($urandom_range(0, 26));
            msg = $urandom() & ((32'd1 << len) - 1);
            code = ref_crc(msg, len);
            tick("R2 init", 1, 0, 0, 0);
            for (int k = len - 1; k >= 0; k--) begin
                if ($urandom_range(0, 3) == 0) tick("R4 gap", 0, 0, $urandom_range(0, 1), 0);
                tick("R3 random", 0, 1, msg[k], 0);
            end
            check("R3 random code", 32'(crc_o), 32'(code));
            if (f % 2 == 0) begin
                for (int k = 4; k >= 0; k--) tick("R6 random check", 0, 1, code[k], 0);
                check("R6 random residue", 32'(residue_ok_o), 1);
            end else begin
                for (int k = 0; k < 7; k++)
                    tick("R7 random drain", 0, $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 2) != 0);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule